// File: doc/BRIEF.md
# Frequency-change recovery watchdog

This block guards a change of the system clock frequency. Control logic programs a timeout length, a time unit, an enable and two reset-enable bits. Once the enable bit is set, each frequency-change pulse arms a countdown. The countdown runs on a slow time-base tick. Each count step lasts a parameterized number of ticks, which stands for either a short unit or a long unit.

If the countdown reaches zero before the next frequency change, the block does three things. It emits a one-cycle expiry event, which a frequency selector uses to fall back to a safe setting. It sets a sticky status flag, which software clears by writing 1. When the matching enable is set, it also drives an active-low system reset pulse of fixed length. A separate enable makes every frequency change produce the same reset pulse, whether or not the watchdog is armed.

Top module: `freq_guard_wdt`

## Requirements
- R1: Reset state of the outputs and settings:
  - `expire_evt` is 0, `expired_sts` is 0 and `sys_rst_n` is 1.
  - The timeout field is 31 (all ones) and the unit select is 0 (short unit).
  - The enable and both reset enables are 0. With these settings, frequency changes and ticks produce no expiry and no reset pulse.
- R2: Expiry timing:
  - Once armed with timeout T, the block expires after T*U ticks. U is SHORT_TICKS when the unit select is 0 and LONG_TICKS when it is 1.
  - A timeout of 0 behaves like a timeout of 1.
  - `expire_evt` is high for exactly one cycle, the cycle after the clock edge that sampled the final tick.
- R3: With the enable at 1, ticks are ignored until a `freq_change` pulse arms the countdown.
- R4: Effect of the enable bit:
  - While the enable is 0, the countdown is stopped and reloaded from the timeout field.
  - Setting the enable again does not resume counting; counting waits for a new `freq_change`.
- R5: Each expiry sets `expired_sts` one cycle after `expire_evt`. It stays set until cleared.
- R6: Clearing the status:
  - A control write with `ctl_clear_sts`=1 clears `expired_sts`.
  - A write with `ctl_clear_sts`=0 leaves it unchanged.
  - An expiry in the same cycle as a clear wins, so the flag stays set.
- R7: Stopping and restarting:
  - After an expiry the countdown stays stopped until a new `freq_change` arrives with the enable at 1.
  - A `freq_change` while counting restarts the count from the full timeout. This restart takes precedence over a tick in the same cycle.
- R8: With `ctl_rst_on_expire`=1, an expiry drives `sys_rst_n` low for RST_PULSE_CYC cycles. The pulse starts on the edge after the `expire_evt` cycle.
- R9: With `ctl_rst_on_change`=1, every `freq_change` drives `sys_rst_n` low for RST_PULSE_CYC cycles from the next edge. This holds whatever the enable bit is.
- R10: If `freq_change` arrives in the same cycle as `expire_evt` and both reset enables are set, exactly one reset pulse of RST_PULSE_CYC cycles is produced. The `freq_change` also re-arms the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_we | input | 1 | Write strobe for the timeout and unit settings |
| tmr_timeout | input | 5 | Timeout length in units |
| tmr_long_unit | input | 1 | Unit select: 0 short, 1 long |
| ctl_we | input | 1 | Write strobe for the control settings |
| ctl_arm_en | input | 1 | Watchdog enable |
| ctl_rst_on_expire | input | 1 | Reset pulse on expiry |
| ctl_rst_on_change | input | 1 | Reset pulse on frequency change |
| ctl_clear_sts | input | 1 | 1 clears the sticky status on a control write |
| freq_change | input | 1 | One-cycle frequency-change pulse |
| time_tick | input | 1 | Time-base tick |
| expire_evt | output | 1 | One-cycle expiry event to the frequency selector |
| expired_sts | output | 1 | Sticky expiry status |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The hardest situation to reach is an expiry that coincides with a frequency change. It needs the final tick placed on an exact cycle and `freq_change` raised during the single cycle that `expire_evt` is high. The stimulus therefore issues the last tick by hand and asserts `freq_change` on the following cycle. It then checks that one reset pulse of the programmed length appears, and that the countdown was re-armed, by expecting a second expiry exactly one timeout later. Reload-on-disable is reached by dropping the enable part-way through a count and confirming that no expiry follows until a fresh frequency change.

// File: rtl/freq_guard_pkg.sv
package freq_guard_pkg;
  localparam int TMO_W = 5;

  typedef struct packed {
    logic [TMO_W-1:0] timeout;
    logic             long_unit;
  } guard_tmr_t;

  typedef struct packed {
    logic arm_en;
    logic rst_on_expire;
    logic rst_on_change;
  } guard_ctl_t;
endpackage

// File: rtl/freq_guard_regs.sv
module freq_guard_regs
  import freq_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_we,
  input  guard_tmr_t       tmr_wdata,
  input  logic             ctl_we,
  input  guard_ctl_t       ctl_wdata,
  input  logic             clear_sts,
  input  logic             expire,
  output guard_tmr_t       tmr_q,
  output guard_ctl_t       ctl_q,
  output logic             sts_q
);
  guard_tmr_t tmr_d;
  guard_ctl_t ctl_d;
  logic       sts_d;

  always_comb begin
    tmr_d = tmr_q;
    ctl_d = ctl_q;
    sts_d = sts_q;
    if (tmr_we) tmr_d = tmr_wdata;
    if (ctl_we) ctl_d = ctl_wdata;
    if (expire)                      sts_d = 1'b1;
    else if (ctl_we && clear_sts)    sts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '{timeout: {TMO_W{1'b1}}, long_unit: 1'b0};
      ctl_q <= '0;
      sts_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      ctl_q <= ctl_d;
      sts_q <= sts_d;
    end
  end

  p_sts_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> sts_q);
  p_sts_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && clear_sts && !expire) |=> !sts_q);
  p_sts_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !(ctl_we && clear_sts)) |=> sts_q);
endmodule

// File: rtl/freq_guard_counter.sv
module freq_guard_counter
  import freq_guard_pkg::*;
#(
  parameter int SHORT_TICKS = 4,
  parameter int LONG_TICKS  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_en,
  input  logic [TMO_W-1:0] timeout,
  input  logic             long_unit,
  input  logic             freq_change,
  input  logic             time_tick,
  output logic             expire_q
);
  localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int PRE_W     = $clog2(MAX_TICKS + 1);
  localparam logic [PRE_W-1:0] SHORT_LAST = PRE_W'(SHORT_TICKS - 1);
  localparam logic [PRE_W-1:0] LONG_LAST  = PRE_W'(LONG_TICKS - 1);

  logic             run_q, run_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             exp_d;
  logic [PRE_W-1:0] unit_last;

  assign unit_last = long_unit ? LONG_LAST : SHORT_LAST;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    pre_d = pre_q;
    exp_d = 1'b0;
    if (!arm_en) begin
      run_d = 1'b0;
      cnt_d = timeout;
      pre_d = '0;
    end else if (freq_change) begin
      run_d = 1'b1;
      cnt_d = timeout;
      pre_d = '0;
    end else if (run_q && time_tick) begin
      if (pre_q >= unit_last) begin
        pre_d = '0;
        if (cnt_q <= TMO_W'(1)) begin
          cnt_d = '0;
          run_d = 1'b0;
          exp_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      pre_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      cnt_q    <= cnt_d;
      pre_q    <= pre_d;
      expire_q <= exp_d;
    end
  end

  p_expire_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);
  p_stop_after_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> !run_q);
  p_disarmed_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_en |=> (!expire_q && !run_q));
  p_change_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_en && freq_change) |=> (run_q && !expire_q));
endmodule

// File: rtl/freq_guard_rstgen.sv
module freq_guard_rstgen #(
  parameter int RST_PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic sys_rst_n
);
  localparam int RC_W = $clog2(RST_PULSE_CYC + 1);

  logic rst_n_q, rst_n_d;

  generate
    if (RST_PULSE_CYC <= 1) begin : g_single
      assign rst_n_d = !trig;
    end else begin : g_count
      logic [RC_W-1:0] rc_q, rc_d;
      always_comb begin
        if (trig)               rc_d = RC_W'(RST_PULSE_CYC);
        else if (rc_q != '0)    rc_d = rc_q - 1'b1;
        else                    rc_d = rc_q;
      end
      assign rst_n_d = (rc_d == '0);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rc_q <= '0;
        else        rc_q <= rc_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_n_q <= 1'b1;
    else        rst_n_q <= rst_n_d;
  end

  assign sys_rst_n = rst_n_q;

  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !sys_rst_n);
endmodule

// File: rtl/freq_guard_wdt.sv
module freq_guard_wdt
  import freq_guard_pkg::*;
#(
  parameter int SHORT_TICKS   = 4,
  parameter int LONG_TICKS    = 12,
  parameter int RST_PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_we,
  input  logic [TMO_W-1:0] tmr_timeout,
  input  logic             tmr_long_unit,
  input  logic             ctl_we,
  input  logic             ctl_arm_en,
  input  logic             ctl_rst_on_expire,
  input  logic             ctl_rst_on_change,
  input  logic             ctl_clear_sts,
  input  logic             freq_change,
  input  logic             time_tick,
  output logic             expire_evt,
  output logic             expired_sts,
  output logic             sys_rst_n
);
  guard_tmr_t tmr_q;
  guard_ctl_t ctl_q;
  guard_tmr_t tmr_w;
  guard_ctl_t ctl_w;
  logic       rst_trig;

  assign tmr_w = '{timeout: tmr_timeout, long_unit: tmr_long_unit};
  assign ctl_w = '{arm_en: ctl_arm_en, rst_on_expire: ctl_rst_on_expire,
                   rst_on_change: ctl_rst_on_change};

  freq_guard_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_we    (tmr_we),
    .tmr_wdata (tmr_w),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_w),
    .clear_sts (ctl_clear_sts),
    .expire    (expire_evt),
    .tmr_q     (tmr_q),
    .ctl_q     (ctl_q),
    .sts_q     (expired_sts)
  );

  freq_guard_counter #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_en      (ctl_q.arm_en),
    .timeout     (tmr_q.timeout),
    .long_unit   (tmr_q.long_unit),
    .freq_change (freq_change),
    .time_tick   (time_tick),
    .expire_q    (expire_evt)
  );

  assign rst_trig = (expire_evt && ctl_q.rst_on_expire) ||
                    (freq_change && ctl_q.rst_on_change);

  freq_guard_rstgen #(
    .RST_PULSE_CYC (RST_PULSE_CYC)
  ) u_rstgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (rst_trig),
    .sys_rst_n (sys_rst_n)
  );

  p_change_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_change && ctl_q.rst_on_change) |=> !sys_rst_n);
endmodule

// File: tb/freq_guard_wdt_tb.sv
module freq_guard_wdt_tb;
  localparam int SHORT = 4;
  localparam int LONG  = 12;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_we = 0, tmr_long_unit = 0;
  logic [4:0] tmr_timeout = '0;
  logic ctl_we = 0, ctl_arm_en = 0, ctl_rst_on_expire = 0, ctl_rst_on_change = 0, ctl_clear_sts = 0;
  logic freq_change = 0, time_tick = 0;
  logic expire_evt, expired_sts, sys_rst_n;

  int checks = 0;
  int errors = 0;
  int tick_total = 0;
  int exp_seen = 0;
  int low_len = 0;
  int exp_q[$];
  int rst_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  freq_guard_wdt #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .RST_PULSE_CYC(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_we(tmr_we), .tmr_timeout(tmr_timeout),
    .tmr_long_unit(tmr_long_unit), .ctl_we(ctl_we), .ctl_arm_en(ctl_arm_en),
    .ctl_rst_on_expire(ctl_rst_on_expire), .ctl_rst_on_change(ctl_rst_on_change),
    .ctl_clear_sts(ctl_clear_sts), .freq_change(freq_change), .time_tick(time_tick),
    .expire_evt(expire_evt), .expired_sts(expired_sts), .sys_rst_n(sys_rst_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected expiries and reset pulse lengths.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (expire_evt) begin
        exp_seen++;
        if (exp_q.size() == 0) check("R7 unexpected expiry at tick", tick_total, -1);
        else check("R2 expiry tick stamp", tick_total, exp_q.pop_front());
      end
      if (!sys_rst_n) low_len++;
      else if (low_len > 0) begin
        if (rst_q.size() == 0) check("R9 unexpected reset pulse length", low_len, 0);
        else check("R8 reset pulse length", low_len, rst_q.pop_front());
        low_len = 0;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); time_tick = 1; tick_total++;
      @(negedge clk); time_tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic fchange();
    @(negedge clk); freq_change = 1;
    @(negedge clk); freq_change = 0;
  endtask

  task automatic wr_tmr(input int to, input bit lng);
    @(negedge clk); tmr_we = 1; tmr_timeout = 5'(to); tmr_long_unit = lng;
    @(negedge clk); tmr_we = 0;
  endtask

  task automatic wr_ctl(input bit arm, input bit rex, input bit rch, input bit clr);
    @(negedge clk); ctl_we = 1; ctl_arm_en = arm; ctl_rst_on_expire = rex;
    ctl_rst_on_change = rch; ctl_clear_sts = clr;
    @(negedge clk); ctl_we = 0; ctl_clear_sts = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 expire_evt after reset", expire_evt, 0);
    check("R1 expired_sts after reset", expired_sts, 0);
    check("R1 sys_rst_n after reset", sys_rst_n, 1);

    // R1: enables default off: no reset pulse, no expiry
    fchange();
    tick(40);
    check("R1 no expiry with defaults", exp_seen, 0);
    check("R1 status stays clear", expired_sts, 0);

    // R3: armed but no frequency change yet -> ticks ignored
    wr_ctl(1, 0, 0, 0);
    tick(10);
    check("R3 no count before change", exp_seen, 0);
    // R2 default timeout 31 short units
    fchange();
    exp_q.push_back(tick_total + 31 * SHORT);
    tick(31 * SHORT + 6);
    check("R2 one expiry with default timeout", exp_seen, 1);
    check("R5 status set", expired_sts, 1);

    // R6 write 0 leaves status, write 1 clears
    wr_ctl(1, 0, 0, 0);
    check("R6 write zero keeps status", expired_sts, 1);
    wr_ctl(1, 0, 0, 1);
    check("R6 write one clears status", expired_sts, 0);
    // R7 stays stopped after expiry
    tick(40);
    check("R7 stopped after expiry", exp_seen, 1);

    // R2 long unit
    wr_tmr(3, 1);
    fchange();
    exp_q.push_back(tick_total + 3 * LONG);
    tick(3 * LONG + 4);
    check("R2 long unit expiry count", exp_seen, 2);

    // R4 disable reloads, re-enable does not resume
    wr_tmr(5, 0);
    fchange();
    tick(10);
    wr_ctl(0, 0, 0, 0);
    wr_ctl(1, 0, 0, 0);
    tick(40);
    check("R4 no resume after re-enable", exp_seen, 2);
    fchange();
    exp_q.push_back(tick_total + 5 * SHORT);
    tick(5 * SHORT + 4);
    check("R4 full reload after disable", exp_seen, 3);

    // R7 restart while counting
    fchange();
    tick(12);
    fchange();
    exp_q.push_back(tick_total + 5 * SHORT);
    tick(5 * SHORT + 4);
    check("R7 restart from full timeout", exp_seen, 4);

    // R2 timeout zero acts as one
    wr_tmr(0, 0);
    fchange();
    exp_q.push_back(tick_total + SHORT);
    tick(SHORT + 2);
    check("R2 timeout zero", exp_seen, 5);

    // R8 reset pulse on expiry
    wr_ctl(1, 1, 0, 1);
    wr_tmr(2, 0);
    fchange();
    exp_q.push_back(tick_total + 2 * SHORT);
    rst_q.push_back(PULSE);
    tick(2 * SHORT + 2);
    idle(8);
    check("R8 pulse consumed", rst_q.size(), 0);

    // R9 reset pulse on change while disarmed
    wr_ctl(0, 0, 1, 0);
    rst_q.push_back(PULSE);
    fchange();
    idle(8);
    check("R9 pulse consumed", rst_q.size(), 0);
    check("R9 no expiry when disarmed", exp_seen, 6);

    // R10 coincident expiry and change
    wr_ctl(1, 1, 1, 0);
    wr_tmr(1, 0);
    rst_q.push_back(PULSE);
    fchange();
    idle(8);
    tick(SHORT - 1);
    @(negedge clk); time_tick = 1; tick_total++;
    exp_q.push_back(tick_total);
    rst_q.push_back(PULSE);
    @(negedge clk); time_tick = 0; freq_change = 1;
    @(negedge clk); freq_change = 0;
    idle(8);
    check("R10 single pulse consumed", rst_q.size(), 0);
    exp_q.push_back(tick_total + SHORT);
    rst_q.push_back(PULSE);
    tick(SHORT + 2);
    idle(8);
    check("R10 re-armed expiry count", exp_seen, 8);

    idle(4);
    check("R2 expiry queue drained", exp_q.size(), 0);
    check("R8 reset queue drained", rst_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule